// File: doc/BRIEF.md
# Execution trace status and data emitter

This block turns instruction-retire events from a processor core into a real-time trace on two 4-bit buses. The status bus gives one code per cycle for whatever the core retired in the previous cycle: nothing, a plain instruction, or a taken jump. The data bus carries the target address of a taken jump, one nibble per cycle. The address is preceded by a marker nibble that tells an external trace probe how many address bytes follow.

Captured nibbles wait in a small queue, so the status bus can report later instructions while older address nibbles are still going out. A 2-bit size select sets how many low-order target bytes are captured, from none up to three. When the queue does not have room for a whole capture, the block holds the core with a stall output and reports a stall code on the status bus. The core keeps the same retire event on its inputs until the stall is released.

Top module: `exec_trace_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the queue is emptied. After that edge, `trc_status` is 0x0, `trc_data` is 0x0 and `core_stall` is low.
- R2: `trc_status` is registered. It shows 0x1 the cycle after a plain retire (`retire_valid`=1, `retire_is_jump`=0). It shows 0x0 the cycle after a cycle with no retire.
- R3: `trc_status` shows 0x5 the cycle after a taken jump is retired without a stall, whatever the size select is.
- R4: An accepted jump with `size_sel` = 1, 2 or 3 first queues a marker nibble of 0x8, 0x9 or 0xA. If the queue was empty, the marker appears on `trc_data` two cycles after the retire.
- R5: After the marker, `trc_data` shows 2×`size_sel` nibbles of the target on consecutive cycles, least significant first: bits 3:0, then 7:4, and so on. With `size_sel` = 0, nothing is queued.
- R6: `trc_data` shows the idle value 0x0 in any cycle that follows a cycle in which the queue was empty.
- R7: `core_stall` is high, combinationally, when a jump with a nonzero size is retiring and its marker plus nibble count (2×`size_sel`+1) exceeds the free queue entries at the start of that cycle. The cycle after a stall, `trc_status` is 0x0 and nothing from that event is queued.
- R8: A capture is queued whole or not at all. `core_stall` is never raised for a plain retire, for an idle cycle, or for a jump with `size_sel` = 0, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Synchronous reset, active low |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_is_jump | input | 1 | The retiring instruction is a taken jump |
| jump_target | input | 32 | Target address of the retiring jump |
| size_sel | input | 2 | Target bytes to capture: 0 to 3 |
| trc_status | output | 4 | Status code: 0x0 idle or stall, 0x1 plain, 0x5 jump |
| trc_data | output | 4 | Marker and address nibbles, 0x0 when idle |
| core_stall | output | 1 | Hold the retiring instruction |

## Verification
The assertions run on every cycle and check the following:
- the status code that follows a plain retire, an accepted jump and a stall;
- that a stall is raised only for a jump that has something to capture;
- that an accepted capture always fits in the free queue entries;
- the marker that appears after a push into an empty queue.

The exact order of the address nibbles, the return to the idle value, and the timing of stall release as the queue drains can only be shown by the bench scenarios. The bench compares every cycle of both buses against an arithmetic queue model. The scenarios sweep all four sizes over varied targets, run back-to-back jumps that force stalls, send plain retires while the queue is full, and reset in the middle of a drain.

// File: rtl/exec_trace_pkg.sv
// Shared constants and helpers for the execution trace emitter.
// Assumes a 4-bit nibble bus and a 2-bit capture size select.
package exec_trace_pkg;
    localparam int NIB_W     = 4;
    localparam int SEL_W     = 2;
    localparam int MAX_BYTES = (1 << SEL_W) - 1;
    localparam int MAX_NIB   = 1 + 2 * MAX_BYTES;
    localparam int CNT_W     = $clog2(MAX_NIB + 1);

    typedef logic [NIB_W-1:0] nibble_t;

    localparam nibble_t ST_NONE   = 4'h0;
    localparam nibble_t ST_PLAIN  = 4'h1;
    localparam nibble_t ST_TAKEN  = 4'h5;
    localparam nibble_t DATA_IDLE = 4'h0;

    // Marker nibble announcing how many address bytes follow (1..3 -> 0x8..0xA).
    function automatic nibble_t size_marker(input logic [SEL_W-1:0] nbytes);
        return 4'h7 + {{(NIB_W-SEL_W){1'b0}}, nbytes};
    endfunction
endpackage

// File: rtl/trace_capture.sv
// Builds the nibble sequence for one jump: marker first, then target
// nibbles least significant first. Assumes ADDR_W covers 4*(MAX_NIB-1) bits.
module trace_capture
    import exec_trace_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                     jump_valid,
    input  logic [ADDR_W-1:0]        target,
    input  logic [SEL_W-1:0]         nbytes,
    output logic [CNT_W-1:0]         nib_cnt,
    output logic [MAX_NIB*NIB_W-1:0] nibs
);
    // Marker occupies slot 0.
    assign nibs[NIB_W-1:0] = size_marker(nbytes);

    // Address nibbles fill the remaining slots in ascending significance.
    for (genvar k = 1; k < MAX_NIB; k++) begin : g_addr_nib
        assign nibs[k*NIB_W +: NIB_W] = target[(k-1)*NIB_W +: NIB_W];
    end

    // Entry count: 2*nbytes + 1 when there is anything to capture.
    always_comb begin
        if (jump_valid && nbytes != '0)
            nib_cnt = CNT_W'({nbytes, 1'b1});
        else
            nib_cnt = '0;
    end
endmodule

// File: rtl/trace_nibble_fifo.sv
// Nibble queue that takes up to MAX_PUSH entries per cycle and gives one.
// Assumes DEPTH is a power of two and the caller never pushes more than free.
module trace_nibble_fifo
    import exec_trace_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int MAX_PUSH = MAX_NIB
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(MAX_PUSH+1)-1:0] push_cnt,
    input  logic [MAX_PUSH*NIB_W-1:0]   push_data,
    input  logic                        pop,
    output nibble_t                     head,
    output logic                        empty,
    output logic [$clog2(DEPTH+1)-1:0]  free
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    nibble_t            mem [DEPTH];
    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W-1:0]   wr_ptr;
    logic [OCC_W-1:0]   occ;
    logic               do_pop;

    assign empty  = (occ == '0);
    assign do_pop = pop && !empty;
    assign head   = mem[rd_ptr];
    assign free   = OCC_W'(DEPTH) - occ;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            wr_ptr <= wr_ptr + PTR_W'(push_cnt);
            occ    <= occ + OCC_W'(push_cnt) - OCC_W'(do_pop);
        end
    end

    // Storage write of the accepted burst at consecutive slots.
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_PUSH; i++) begin
            if (i < int'(push_cnt))
                mem[wr_ptr + PTR_W'(i)] <= push_data[i*NIB_W +: NIB_W];
        end
    end

    a_r7_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
        int'(push_cnt) <= int'(free));
    a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);
endmodule

// File: rtl/trace_output_stage.sv
// Registers the status code for the previous retire and drains one queued
// nibble per cycle onto the data bus. Assumes stall is already qualified.
module trace_output_stage
    import exec_trace_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    retire_valid,
    input  logic    retire_is_jump,
    input  logic    stall,
    input  logic    q_empty,
    input  nibble_t q_head,
    output logic    q_pop,
    output nibble_t status,
    output nibble_t data
);
    assign q_pop = !q_empty;

    // Status code for the event presented this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   status <= ST_NONE;
        else if (!retire_valid || stall) status <= ST_NONE;
        else if (retire_is_jump)      status <= ST_TAKEN;
        else                          status <= ST_PLAIN;
    end

    // Data bus shows the queue head, or idle when nothing waits.
    always_ff @(posedge clk) begin
        if (!rst_n)       data <= DATA_IDLE;
        else if (q_empty) data <= DATA_IDLE;
        else              data <= q_head;
    end
endmodule

// File: rtl/exec_trace_port.sv
// Execution trace emitter: status code per retire, queued jump targets on
// the data bus, and a stall when a whole capture does not fit.
// Assumes the core holds its retire inputs while core_stall is high.
module exec_trace_port
    import exec_trace_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_valid,
    input  logic              retire_is_jump,
    input  logic [ADDR_W-1:0] jump_target,
    input  logic [1:0]        size_sel,
    output logic [3:0]        trc_status,
    output logic [3:0]        trc_data,
    output logic              core_stall
);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]         cap_cnt;
    logic [MAX_NIB*NIB_W-1:0] cap_nibs;
    logic [CNT_W-1:0]         push_cnt;
    logic [OCC_W-1:0]         fifo_free;
    logic                     fifo_empty;
    logic                     fifo_pop;
    nibble_t                  fifo_head;

    trace_capture #(.ADDR_W(ADDR_W)) u_capture (
        .jump_valid (retire_valid && retire_is_jump),
        .target     (jump_target),
        .nbytes     (size_sel),
        .nib_cnt    (cap_cnt),
        .nibs       (cap_nibs)
    );

    // Stall when the whole capture does not fit; otherwise push it all.
    always_comb begin
        core_stall = (cap_cnt != '0) && (32'(cap_cnt) > 32'(fifo_free));
        push_cnt   = core_stall ? '0 : cap_cnt;
    end

    trace_nibble_fifo #(.DEPTH(DEPTH), .MAX_PUSH(MAX_NIB)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_cnt  (push_cnt),
        .push_data (cap_nibs),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .free      (fifo_free)
    );

    trace_output_stage u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .retire_valid   (retire_valid),
        .retire_is_jump (retire_is_jump),
        .stall          (core_stall),
        .q_empty        (fifo_empty),
        .q_head         (fifo_head),
        .q_pop          (fifo_pop),
        .status         (trc_status),
        .data           (trc_data)
    );

    a_r2_plain_status: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !retire_is_jump) |=> (trc_status == ST_PLAIN));
    a_r3_taken_status: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && retire_is_jump && !core_stall) |=> (trc_status == ST_TAKEN));
    a_r7_stall_status: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |=> (trc_status == ST_NONE));
    a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> (retire_valid && retire_is_jump && size_sel != 2'd0));
    a_r4_marker_first: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt != '0 && fifo_empty) |=> ##1
        (trc_data == size_marker($past(size_sel, 2))));
endmodule

// File: tb/test_exec_trace_port.sv
module test_exec_trace_port;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_valid = 1'b0;
    logic        retire_is_jump = 1'b0;
    logic [31:0] jump_target = '0;
    logic [1:0]  size_sel = '0;
    logic [3:0]  trc_status;
    logic [3:0]  trc_data;
    logic        core_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exec_trace_port #(.ADDR_W(32), .DEPTH(DEPTH)) i_exec_trace_port (
        .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid),
        .retire_is_jump(retire_is_jump), .jump_target(jump_target),
        .size_sel(size_sel), .trc_status(trc_status), .trc_data(trc_data),
        .core_stall(core_stall));

    always #2 clk = ~clk;

    // Event list and reference model state.
    logic        ev_valid[$];
    logic        ev_jump[$];
    logic [31:0] ev_tgt[$];
    logic [1:0]  ev_sz[$];
    logic [3:0]  mq[$];
    int          mtag[$];
    logic [3:0]  exp_status = 4'h0;
    logic [3:0]  exp_data   = 4'h0;
    int          exp_dtag   = 6;
    int          stalls_seen = 0;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic add_ev(input logic v, input logic j, input logic [31:0] t, input logic [1:0] s);
        ev_valid.push_back(v); ev_jump.push_back(j);
        ev_tgt.push_back(t);   ev_sz.push_back(s);
    endtask

    // Compare the registered outputs against the model (at negedge).
    task automatic check_outputs();
        if (exp_status == 4'h5)      check("R3 status", trc_status, exp_status);
        else if (exp_status == 4'h1) check("R2 status", trc_status, exp_status);
        else                         check("R2/R7 status", trc_status, exp_status);
        if (exp_dtag == 4)      check("R4 marker", trc_data, exp_data);
        else if (exp_dtag == 5) check("R5 nibble", trc_data, exp_data);
        else                    check("R6 idle data", trc_data, exp_data);
    endtask

    // Run all queued events, honouring stall by holding the event.
    task automatic run_events();
        while (ev_valid.size() != 0) begin
            logic v, j, mstall;
            logic [31:0] t;
            logic [1:0] s;
            int need;
            v = ev_valid[0]; j = ev_jump[0]; t = ev_tgt[0]; s = ev_sz[0];
            retire_valid = v; retire_is_jump = j; jump_target = t; size_sel = s;
            need = (v && j && s != 0) ? 2 * s + 1 : 0;
            mstall = (need != 0) && (need > DEPTH - mq.size());
            #1;
            if (mstall || need != 0) check("R7 stall", {3'b0, core_stall}, {3'b0, mstall});
            else                     check("R8 no stall", {3'b0, core_stall}, 4'h0);
            if (mstall) stalls_seen++;
            @(posedge clk);
            exp_status = (!v || mstall) ? 4'h0 : (j ? 4'h5 : 4'h1);
            if (mq.size() != 0) begin
                exp_data = mq.pop_front();
                exp_dtag = mtag.pop_front();
            end else begin
                exp_data = 4'h0;
                exp_dtag = 6;
            end
            if (!mstall && need != 0) begin
                mq.push_back(4'h7 + {2'b0, s});
                mtag.push_back(4);
                for (int k = 0; k < 2 * s; k++) begin
                    mq.push_back(t[k*4 +: 4]);
                    mtag.push_back(5);
                end
            end
            if (!mstall) begin
                void'(ev_valid.pop_front()); void'(ev_jump.pop_front());
                void'(ev_tgt.pop_front());   void'(ev_sz.pop_front());
            end
            @(negedge clk);
            check_outputs();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) add_ev(1'b0, 1'b0, 32'h0, 2'd0);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 status", trc_status, 4'h0);
        check("R1 data", trc_data, 4'h0);
        check("R1 stall", {3'b0, core_stall}, 4'h0);
        rst_n = 1'b1;

        // Directed 2-byte jump: stream 9, D, C, B, A (R4, R5).
        add_ev(1'b1, 1'b1, 32'h1234_ABCD, 2'd2);
        idle(7);
        // Sweep sizes with plain retires interleaved.
        for (int n = 0; n < 24; n++) begin
            add_ev(1'b1, 1'b1, 32'h9E37_79B9 * (n + 1), 2'(n % 4));
            add_ev(1'b1, 1'b0, 32'h0, 2'd0);
            if (n % 3 == 0) idle(2);
        end
        idle(10);
        // Back-to-back jumps forcing stalls (R7), sizes 2 and 3.
        for (int n = 0; n < 6; n++) add_ev(1'b1, 1'b1, 32'hA5C3_0F1E + n * 32'h0101_0101, 2'd2);
        for (int n = 0; n < 4; n++) add_ev(1'b1, 1'b1, 32'h0BAD_F00D ^ (n << 8), 2'd3);
        // Queue full, plain retires and size-0 jumps never stall (R8).
        add_ev(1'b1, 1'b1, 32'h7654_3210, 2'd3);
        for (int n = 0; n < 4; n++) add_ev(1'b1, 1'b0, 32'h0, 2'd0);
        add_ev(1'b1, 1'b1, 32'hFFFF_FFFF, 2'd0);
        idle(12);
        run_events();
        if (stalls_seen == 0) begin
            checks++; fails++;
            $display("FAIL R7 no stall was provoked actual=0 expected>0");
        end

        // Reset in the middle of a drain empties the queue (R1).
        add_ev(1'b1, 1'b1, 32'hCAFE_1234, 2'd3);
        add_ev(1'b0, 1'b0, 32'h0, 2'd0);
        run_events();
        retire_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete(); mtag.delete();
        check("R1 status after reset", trc_status, 4'h0);
        check("R1 data after reset", trc_data, 4'h0);
        exp_status = 4'h0; exp_data = 4'h0; exp_dtag = 6;
        idle(4);
        run_events();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule